// File: doc/BRIEF.md
# Colour RAM Address Translation Decoder

This block sits between a byte-wide CPU memory port and two on-chip memories. One is a main memory stored as 64-bit words. The other is a byte-wide colour RAM. Each access carries a 28-bit flat address, a read or write strobe and one byte of write data. The block decides which memory the access reaches and works out the address inside that memory. For main memory it also picks the byte lane. One cycle after the strobe it returns a single completion pulse, and on a read the data comes with that pulse.

The colour RAM can be reached through three address windows. The first is an extended window that covers the whole colour RAM. The second is a window in the legacy I/O area, 1KB or 2KB wide, which is open only while I/O is visible. The third is a fixed window over the top 2KB of main memory. That window always goes to colour RAM, so the main-memory bytes beneath it can never be read or written by the requester. Every window uses the same completion path, so a write through any of them ends the access cleanly.

The memory sizes are parameters. `MAIN_AW` is the number of main-memory byte-address bits and `CRAM_AW` is the number of colour-RAM address bits. All addresses below assume MAIN_AW=17 (128KB) and CRAM_AW=16 (64KB).

Top module: `cram_xlate`

## Requirements
- R1: `acc_done` is low during and right after reset. It goes high exactly one cycle after each cycle in which `acc_rd` or `acc_wr` is high, and is low in every other cycle.
- R2: Read data appears on `acc_rdata` in the same cycle as `acc_done`. It is the byte most recently written at the location the read address decodes to.
- R3: Main-memory byte address A lives in word A>>3, in byte lane A[2:0] (lane n is bits 8n+7..8n). A write changes only that lane, and the other seven bytes of the word keep their values.
- R4: Addresses 0xFF80000 to 0xFF8FFFF reach colour RAM at offset addr[15:0].
- R5: While `io_visible` is high and `wide_io` is low, addresses 0xD800 to 0xDBFF reach colour RAM at offset addr-0xD800.
- R6: While `io_visible` and `wide_io` are both high, addresses 0xD800 to 0xDFFF reach colour RAM at offset addr-0xD800.
- R7: While `io_visible` is low, addresses 0xD800 to 0xDFFF reach main memory at the same address.
- R8: Addresses 0x1F800 to 0x1FFFF always reach colour RAM at offset addr-0x1F800, so they alias the same colour RAM bytes as the I/O window. A write there leaves every main-memory byte unchanged.
- R9: An address that hits no window and lies at or above 0x20000 reads as 0xFF. A write to it changes neither memory. Both still produce `acc_done`.
- R10: While `io_visible` is high and `wide_io` is low, addresses 0xDC00 to 0xDFFF reach main memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_rd | input | 1 | Read strobe, one cycle per access |
| acc_wr | input | 1 | Write strobe, one cycle per access |
| acc_addr | input | 28 | Flat byte address |
| acc_wdata | input | 8 | Write byte |
| io_visible | input | 1 | Opens the legacy I/O colour window |
| wide_io | input | 1 | Widens the I/O window from 1KB to 2KB |
| acc_done | output | 1 | Completion pulse, one cycle after a strobe |
| acc_rdata | output | 8 | Read byte, valid with `acc_done` after a read |

## Verification
The assertions assume that read and write are never strobed in the same cycle, and that the address and control inputs are held steady during any strobe cycle. The bench meets both conditions. It raises exactly one strobe per access and changes inputs only on the falling edge. It also leaves a quiet cycle between accesses, so the check that completion is absent when no strobe was given is exercised. The random stimulus draws addresses from small pools in every window and in the unmapped space. It picks `io_visible` and `wide_io` at random for each access, so the same colour RAM bytes are written through one window and read back through another.

// File: rtl/cram_xlate.sv
module cram_xlate #(
  parameter int ADDR_W  = 28,
  parameter int MAIN_AW = 13,
  parameter int CRAM_AW = 11,
  parameter int LANES   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  input  logic              io_visible,
  input  logic              wide_io,
  output logic              acc_done,
  output logic [7:0]        acc_rdata
);
  localparam int LANE_AW    = $clog2(LANES);
  localparam int WORD_W     = 8 * LANES;
  localparam int MAIN_WORDS = 1 << (MAIN_AW - LANE_AW);
  localparam int WIDX_W     = MAIN_AW - LANE_AW;
  localparam int CRAM_BYTES = 1 << CRAM_AW;
  localparam int SHADOW_AW  = 11;
  localparam logic [ADDR_W-1:0] MAIN_TOP    = ADDR_W'(1) << MAIN_AW;
  localparam logic [ADDR_W-1:0] SHADOW_BASE = MAIN_TOP - (ADDR_W'(1) << SHADOW_AW);
  localparam logic [ADDR_W-1:0] IO_BASE     = ADDR_W'(28'hD800);
  localparam logic [ADDR_W-1:0] IO_END_N    = ADDR_W'(28'hDBFF);
  localparam logic [ADDR_W-1:0] IO_END_W    = ADDR_W'(28'hDFFF);
  localparam logic [11:0]       EXT_TAG     = 12'hFF8;

  typedef enum logic [1:0] {TGT_NONE, TGT_MAIN, TGT_CRAM} tgt_t;

  logic [WORD_W-1:0] main_mem [MAIN_WORDS];
  logic [7:0]        cram_mem [CRAM_BYTES];

  logic hit_ext, hit_io, hit_shadow, hit_main;
  logic [ADDR_W-1:0] io_end;
  tgt_t              tgt;
  logic [CRAM_AW-1:0] cram_off;
  logic [WIDX_W-1:0]  widx;
  logic [LANE_AW-1:0] lane;
  logic               strobe;
  logic               cram_we;
  logic [LANES-1:0]   main_be;

  assign strobe     = acc_rd | acc_wr;
  assign io_end     = wide_io ? IO_END_W : IO_END_N;
  assign hit_ext    = acc_addr[ADDR_W-1:16] == EXT_TAG;
  assign hit_io     = io_visible && acc_addr >= IO_BASE && acc_addr <= io_end;
  assign hit_shadow = acc_addr >= SHADOW_BASE && acc_addr < MAIN_TOP;
  assign hit_main   = acc_addr < MAIN_TOP;

  always_comb begin
    tgt      = TGT_NONE;
    cram_off = '0;
    if (hit_ext) begin
      tgt      = TGT_CRAM;
      cram_off = acc_addr[CRAM_AW-1:0];
    end else if (hit_io || hit_shadow) begin
      tgt      = TGT_CRAM;
      cram_off = CRAM_AW'(acc_addr[SHADOW_AW-1:0]);
    end else if (hit_main) begin
      tgt      = TGT_MAIN;
    end
  end

  assign widx    = acc_addr[MAIN_AW-1:LANE_AW];
  assign lane    = acc_addr[LANE_AW-1:0];
  assign cram_we = acc_wr && tgt == TGT_CRAM;

  always_comb begin
    main_be = '0;
    if (acc_wr && tgt == TGT_MAIN) main_be[lane] = 1'b1;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (main_be[i]) main_mem[widx][i*8 +: 8] <= acc_wdata;
    if (cram_we) cram_mem[cram_off] <= acc_wdata;
  end

  logic [WORD_W-1:0]  main_q;
  logic [7:0]         cram_q;
  logic [LANE_AW-1:0] lane_q;
  tgt_t               tgt_q;

  always_ff @(posedge clk) begin
    if (acc_rd && tgt == TGT_MAIN) main_q <= main_mem[widx];
    if (acc_rd && tgt == TGT_CRAM) cram_q <= cram_mem[cram_off];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_done <= 1'b0;
      tgt_q    <= TGT_NONE;
      lane_q   <= '0;
    end else begin
      acc_done <= strobe;
      if (strobe) begin
        tgt_q  <= acc_rd ? tgt : TGT_NONE;
        lane_q <= lane;
      end
    end
  end

  always_comb begin
    case (tgt_q)
      TGT_MAIN: acc_rdata = main_q[lane_q*8 +: 8];
      TGT_CRAM: acc_rdata = cram_q;
      default:  acc_rdata = 8'hFF;
    endcase
  end

  a_r1_done_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd || acc_wr) |=> acc_done);

  a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_rd || acc_wr) |=> !acc_done);

  a_r3_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(main_be));

  a_r8_shadow_never_in_main: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_addr >= SHADOW_BASE && acc_addr < MAIN_TOP) |-> (main_be == '0 && cram_we));

  a_r9_unmapped_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !acc_wr && acc_addr >= MAIN_TOP && acc_addr[ADDR_W-1:16] != EXT_TAG
     && acc_addr[ADDR_W-1:16] != '0) |=> (acc_done && acc_rdata == 8'hFF));

  a_r9_unmapped_writes_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr >= MAIN_TOP && acc_addr[ADDR_W-1:16] != EXT_TAG && acc_addr[ADDR_W-1:16] != '0)
    |-> (main_be == '0 && !cram_we));
endmodule

// File: tb/cram_xlate_test.sv
module cram_xlate_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_rd = 1'b0, acc_wr = 1'b0;
  logic [27:0] acc_addr = '0;
  logic [7:0]  acc_wdata = '0;
  logic        io_visible = 1'b0, wide_io = 1'b0;
  logic        acc_done;
  logic [7:0]  acc_rdata;

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;

  logic [7:0] main_m [int];
  logic [7:0] cram_m [int];

  cram_xlate #(.MAIN_AW(17), .CRAM_AW(16)) uut (
    .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .io_visible(io_visible),
    .wide_io(wide_io), .acc_done(acc_done), .acc_rdata(acc_rdata));

  always #(CLK_NS/2) clk = ~clk;

  // kind: 0 none, 1 main, 2 colour
  function automatic int decode(input logic [27:0] a, input bit vis, input bit wide, output int idx);
    idx = 0;
    if (a >= 28'hFF80000 && a <= 28'hFF8FFFF) begin idx = int'(a - 28'hFF80000); return 2; end
    if (vis && a >= 28'hD800 && a <= (wide ? 28'hDFFF : 28'hDBFF)) begin idx = int'(a - 28'hD800); return 2; end
    if (a >= 28'h1F800 && a <= 28'h1FFFF) begin idx = int'(a - 28'h1F800); return 2; end
    if (a < 28'h20000) begin idx = int'(a); return 1; end
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic op(input bit wr, input logic [27:0] a, input logic [7:0] d,
                    input bit vis, input bit wide, input string req);
    int idx, kind;
    bit known;
    logic [7:0] exp;
    kind = decode(a, vis, wide, idx);
    @(negedge clk);
    acc_rd = !wr; acc_wr = wr; acc_addr = a; acc_wdata = d;
    io_visible = vis; wide_io = wide;
    @(negedge clk);
    acc_rd = 1'b0; acc_wr = 1'b0;
    check(acc_done === 1'b1, {req, " done"}, {7'd0, acc_done}, 8'h01);
    if (wr) begin
      if (kind == 1) main_m[idx] = d;
      else if (kind == 2) cram_m[idx] = d;
    end else begin
      known = 1; exp = 8'hFF;
      if (kind == 1) begin known = main_m.exists(idx); if (known) exp = main_m[idx]; end
      else if (kind == 2) begin known = cram_m.exists(idx); if (known) exp = cram_m[idx]; end
      if (known) check(acc_rdata === exp, req, acc_rdata, exp);
    end
    @(negedge clk);
    check(acc_done === 1'b0, {req, " idle"}, {7'd0, acc_done}, 8'h00);
  endtask

  function automatic logic [27:0] pick_addr(input int r, input int k);
    case (r)
      0: return 28'hFF80000 + 28'(k);
      1: return 28'hD800 + 28'(k);
      2: return 28'h1F800 + 28'(k);
      3: return 28'h0100 + 28'(k);
      4: return 28'hDC00 + 28'(k);
      5: return 28'hFF80400 + 28'(k);
      6: return 28'h20000 + 28'(k);
      default: return 28'hFF90000 + 28'(k);
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(acc_done === 1'b0, "R1 reset", {7'd0, acc_done}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check(acc_done === 1'b0, "R1 after reset", {7'd0, acc_done}, 8'h00);

    for (int i = 0; i < 8; i++) op(1, 28'h0400 + 28'(i), 8'h10 + 8'(i), 0, 0, "R3 fill");
    op(1, 28'h0403, 8'hA5, 0, 0, "R3 lane write");
    for (int i = 0; i < 8; i++) op(0, 28'h0400 + 28'(i), 0, 0, 0, "R3 lane readback");

    op(1, 28'hFF8ABCD, 8'h3C, 0, 0, "R4 write");
    op(0, 28'hFF8ABCD, 0, 1, 1, "R4 read");
    op(1, 28'hFF8FFFF, 8'h7E, 0, 0, "R4 top");
    op(0, 28'hFF8FFFF, 0, 0, 0, "R4 top read");

    op(1, 28'hD805, 8'h55, 1, 0, "R5 write");
    op(0, 28'hFF80005, 0, 0, 0, "R5 alias ext");
    op(0, 28'h1F805, 0, 0, 0, "R8 alias io");
    op(1, 28'hDBFF, 8'h66, 1, 0, "R5 edge");
    op(0, 28'hFF803FF, 0, 0, 0, "R5 edge ext");

    op(1, 28'hDFFF, 8'h77, 1, 1, "R6 write");
    op(0, 28'hFF807FF, 0, 0, 0, "R6 ext");
    op(0, 28'h1FFFF, 0, 0, 0, "R8 top alias");

    op(1, 28'hDC10, 8'h99, 1, 0, "R10 write main");
    op(0, 28'hFF80410, 0, 0, 0, "R10 colour untouched");
    op(0, 28'hDC10, 0, 0, 0, "R10 main read");

    op(1, 28'hD820, 8'h42, 0, 0, "R7 write main");
    op(1, 28'hFF80020, 8'h24, 0, 0, "R7 colour");
    op(0, 28'hD820, 0, 0, 0, "R7 main read");
    op(0, 28'hD820, 0, 1, 0, "R7 visible read");

    op(1, 28'h1F7FF, 8'hC3, 0, 0, "R8 below");
    op(1, 28'h1F800, 8'h18, 0, 0, "R8 shadow write");
    op(0, 28'h1F7FF, 0, 0, 0, "R8 main intact");
    op(0, 28'hFF80000, 0, 0, 0, "R8 shadow ext");

    op(1, 28'h0020000, 8'hEE, 0, 0, "R9 write");
    op(0, 28'h0020000, 0, 0, 0, "R9 read");
    op(0, 28'h0000000, 0, 0, 0, "R9 main zero unset");
    op(1, 28'hFF90000, 8'hEE, 0, 0, "R9 write hi");
    op(0, 28'hFF90000, 0, 0, 0, "R9 read hi");
    op(0, 28'hFF80000, 0, 0, 0, "R9 colour untouched");

    for (int r = 0; r < 8; r++)
      for (int k = 0; k < 16; k++)
        op(1, pick_addr(r, k), 8'(r * 16 + k), 0, 0, "R2 preload");

    void'($urandom(32'h1F800));
    for (int n = 0; n < 1500; n++) begin
      int r, k;
      bit wr, vis, wide;
      r = int'($urandom_range(0, 7));
      k = int'($urandom_range(0, 15));
      wr = $urandom_range(0, 2) == 0;
      vis = $urandom_range(0, 1) == 1;
      wide = $urandom_range(0, 1) == 1;
      op(wr, pick_addr(r, k), 8'($urandom), vis, wide, "R2 random");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vectors++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule